// File: doc/BRIEF.md
# Multiframe Signaling Snapshot Capture

This block listens to the serial transmit-side signaling stream. It counts bit and slot positions with the same bit strobe and frame sync that clock the PCM data stream. A frame holds either 24 slots (T1) or 32 slots (E1), and each slot is 8 bits long. Within each slot, the first four bits received carry that channel's A, B, C and D signaling bits. The last four bits of each slot are discarded.

Signaling is not sampled continuously. The block collects the nibbles into a shadow store only during a frame whose sync is flagged as the start of a multiframe. On the bit edge that samples the final bit of that frame, it copies the whole shadow into a per-slot signaling table in one step. Other logic reads the table through a combinational port addressed by slot number.

Top module: `sig_mf_capture`

## Requirements
- R1: After reset, every one of the 32 table entries reads 0000.
- R2: A bit is taken on each rising clock edge where `bit_en` is high. `frame_sync` high together with `bit_en` marks bit 0 of slot 0. Slots are 8 bits long and are sent MSB first. A frame has 32 slots when `e1_mode` is 1 and 24 slots when it is 0.
- R3: The table entry for a slot holds the first four bits of that slot. Bit 3 of the entry is A, the first bit received, and bit 0 is D, the fourth. The last four bits of the slot have no effect.
- R4: A frame is captured only when `mf_start` is high at its `frame_sync` bit. Frames without that flag leave every entry unchanged.
- R5: All entries change together, on the edge that samples bit 7 of the last slot of a captured frame. Before that edge, reads return the previous contents.
- R6: A T1 capture writes entries 0 to 23 and leaves entries 24 to 31 unchanged.
- R7: If a new `frame_sync` arrives before a capture has finished, that capture is abandoned and produces no update, unless the new sync itself carries `mf_start`.
- R8: Cycles with `bit_en` low do not advance the position and sample nothing, so a gapped bit strobe captures the same values as a continuous one.
- R9: `rd_data` is the table entry at `rd_addr` in the same cycle, with no register in the path.
- R10: When no new sync arrives, the position wraps from the last slot back to slot 0. The frame that follows is not captured and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit strobe; one serial bit is taken per high cycle |
| frame_sync | input | 1 | First bit of a frame; only counts while `bit_en` is high |
| mf_start | input | 1 | With `frame_sync`: this frame opens a multiframe |
| e1_mode | input | 1 | 1 selects 32-slot frames, 0 selects 24-slot frames |
| sig_bit | input | 1 | Serial signaling data |
| rd_addr | input | 5 | Slot number to read |
| rd_data | output | 4 | ABCD entry of that slot (A in bit 3) |

## Verification
The table changes on the edge that samples the final bit of a captured frame. The new value can therefore be read at the next falling edge, and the read port shows it in the same cycle the address is set. The bench drives each bit at a falling edge and drops the strobe one cycle later. It checks the table just before the last bit of a captured frame, where it must still hold the old contents, and again right after that bit, where it must hold the new ones. Every read settles the address for 1 ns before comparing, so all comparisons occur away from the clock edge. The atomic update, the T1 upper-entry hold and the position stepping are also checked cycle by cycle by the bound properties.

// File: rtl/sig_cap_pkg.sv
package sig_cap_pkg;

  typedef enum logic {CAP_IDLE, CAP_RUN} cap_state_e;

  // Index of the final slot in a frame for the selected line mode.
  function automatic int last_slot(input logic e1, input int n_e1, input int n_t1);
    return e1 ? (n_e1 - 1) : (n_t1 - 1);
  endfunction

  // Storage lane for the k-th received signaling bit: A (k=0) lands in the MSB.
  function automatic int sig_lane(input int k, input int sig_w);
    return sig_w - 1 - k;
  endfunction

endpackage

// File: rtl/sig_pos_counter.sv
module sig_pos_counter #(
  parameter int N_SLOTS_E1 = 32,
  parameter int N_SLOTS_T1 = 24,
  parameter int SLOT_BITS  = 8,
  localparam int SLOT_W = $clog2(N_SLOTS_E1),
  localparam int BIT_W  = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_sync,
  input  logic              e1_mode,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [BIT_W-1:0]  cur_bit,
  output logic              frame_end
);

  logic [SLOT_W-1:0] cnt_slot;
  logic [BIT_W-1:0]  cnt_bit;
  logic [SLOT_W-1:0] last_idx;
  logic              sync_ev;
  logic              bit_last;
  logic              slot_last;

  assign sync_ev  = bit_en && frame_sync;
  assign last_idx = SLOT_W'(sig_cap_pkg::last_slot(e1_mode, N_SLOTS_E1, N_SLOTS_T1));

  // Position of the bit on the line this cycle: a sync forces slot 0, bit 0.
  always_comb begin
    cur_slot = sync_ev ? '0 : cnt_slot;
    cur_bit  = sync_ev ? '0 : cnt_bit;
  end

  assign bit_last  = (cur_bit == BIT_W'(SLOT_BITS - 1));
  assign slot_last = (cur_slot >= last_idx);
  assign frame_end = bit_en && bit_last && slot_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_slot <= '0;
      cnt_bit  <= '0;
    end else if (bit_en) begin
      if (bit_last) begin
        cnt_bit  <= '0;
        cnt_slot <= slot_last ? '0 : cur_slot + 1'b1;
      end else begin
        cnt_bit  <= cur_bit + 1'b1;
        cnt_slot <= cur_slot;
      end
    end
  end

endmodule

// File: rtl/sig_capture_ctrl.sv
module sig_capture_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic frame_sync,
  input  logic mf_start,
  input  logic frame_end,
  output logic cap_now,
  output logic wr_en,
  output logic commit
);

  import sig_cap_pkg::*;

  cap_state_e cap_q;
  logic       sync_ev;

  assign sync_ev = bit_en && frame_sync;

  // The sync bit itself already belongs to the frame it opens.
  assign cap_now = sync_ev ? mf_start : (cap_q == CAP_RUN);
  assign wr_en   = bit_en && cap_now;
  assign commit  = cap_now && frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= CAP_IDLE;
    end else if (commit) begin
      cap_q <= CAP_IDLE;
    end else if (sync_ev) begin
      cap_q <= mf_start ? CAP_RUN : CAP_IDLE;
    end
  end

endmodule

// File: rtl/sig_shadow_store.sv
module sig_shadow_store #(
  parameter int N_SLOTS_E1 = 32,
  parameter int SLOT_BITS  = 8,
  parameter int SIG_W      = 4,
  localparam int SLOT_W = $clog2(N_SLOTS_E1),
  localparam int BIT_W  = $clog2(SLOT_BITS),
  localparam int LANE_W = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SLOT_W-1:0]           cur_slot,
  input  logic [BIT_W-1:0]            cur_bit,
  input  logic                        sig_bit,
  output logic [N_SLOTS_E1*SIG_W-1:0] shadow_flat
);

  logic [SIG_W-1:0]  shadow [N_SLOTS_E1];
  logic [LANE_W-1:0] lane;
  logic              in_nibble;

  assign in_nibble = (int'(cur_bit) < SIG_W);
  assign lane      = LANE_W'(sig_cap_pkg::sig_lane(int'(cur_bit), SIG_W));

  for (genvar s = 0; s < N_SLOTS_E1; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[s] <= '0;
      end else if (wr_en && in_nibble && (cur_slot == SLOT_W'(s))) begin
        shadow[s][lane] <= sig_bit;
      end
    end
    assign shadow_flat[s*SIG_W +: SIG_W] = shadow[s];
  end

endmodule

// File: rtl/sig_entry_buffer.sv
module sig_entry_buffer #(
  parameter int N_SLOTS_E1 = 32,
  parameter int N_SLOTS_T1 = 24,
  parameter int SIG_W      = 4,
  localparam int SLOT_W = $clog2(N_SLOTS_E1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic                        e1_mode,
  input  logic [N_SLOTS_E1*SIG_W-1:0] shadow_flat,
  input  logic [SLOT_W-1:0]           rd_addr,
  output logic [SIG_W-1:0]            rd_data,
  output logic [N_SLOTS_E1*SIG_W-1:0] buf_flat
);

  logic [SIG_W-1:0] entry [N_SLOTS_E1];

  for (genvar s = 0; s < N_SLOTS_E1; s++) begin : g_entry
    localparam bit IN_T1 = (s < N_SLOTS_T1);
    logic upd;
    // Entries beyond the short frame are only written by a long-frame capture.
    assign upd = commit && (IN_T1 || e1_mode);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry[s] <= '0;
      end else if (upd) begin
        entry[s] <= shadow_flat[s*SIG_W +: SIG_W];
      end
    end
    assign buf_flat[s*SIG_W +: SIG_W] = entry[s];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < N_SLOTS_E1) rd_data = entry[rd_addr];
  end

endmodule

// File: rtl/sig_mf_capture.sv
module sig_mf_capture #(
  parameter int N_SLOTS_E1 = 32,
  parameter int N_SLOTS_T1 = 24,
  parameter int SLOT_BITS  = 8,
  parameter int SIG_W      = 4,
  localparam int SLOT_W = $clog2(N_SLOTS_E1),
  localparam int BIT_W  = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_sync,
  input  logic              mf_start,
  input  logic              e1_mode,
  input  logic              sig_bit,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [SIG_W-1:0]  rd_data
);

  // Named internal events, visible to the bound checker.
  logic [SLOT_W-1:0]           cur_slot;
  logic [BIT_W-1:0]            cur_bit;
  logic                        frame_end;
  logic                        cap_now;
  logic                        wr_en;
  logic                        commit;
  logic [N_SLOTS_E1*SIG_W-1:0] shadow_flat;
  logic [N_SLOTS_E1*SIG_W-1:0] buf_flat;

  sig_pos_counter #(
    .N_SLOTS_E1(N_SLOTS_E1), .N_SLOTS_T1(N_SLOTS_T1), .SLOT_BITS(SLOT_BITS)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .e1_mode(e1_mode), .cur_slot(cur_slot), .cur_bit(cur_bit), .frame_end(frame_end)
  );

  sig_capture_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .mf_start(mf_start), .frame_end(frame_end), .cap_now(cap_now),
    .wr_en(wr_en), .commit(commit)
  );

  sig_shadow_store #(
    .N_SLOTS_E1(N_SLOTS_E1), .SLOT_BITS(SLOT_BITS), .SIG_W(SIG_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cur_slot(cur_slot),
    .cur_bit(cur_bit), .sig_bit(sig_bit), .shadow_flat(shadow_flat)
  );

  sig_entry_buffer #(
    .N_SLOTS_E1(N_SLOTS_E1), .N_SLOTS_T1(N_SLOTS_T1), .SIG_W(SIG_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .commit(commit), .e1_mode(e1_mode),
    .shadow_flat(shadow_flat), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_flat(buf_flat)
  );

endmodule

// File: rtl/sig_mf_capture_chk.sv
module sig_mf_capture_chk #(
  parameter int N_SLOTS_E1 = 32,
  parameter int N_SLOTS_T1 = 24,
  parameter int SLOT_BITS  = 8,
  parameter int SIG_W      = 4,
  localparam int SLOT_W = $clog2(N_SLOTS_E1),
  localparam int BIT_W  = $clog2(SLOT_BITS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bit_en,
  input logic                        frame_sync,
  input logic                        mf_start,
  input logic [SLOT_W-1:0]           cur_slot,
  input logic [BIT_W-1:0]            cur_bit,
  input logic                        cap_now,
  input logic                        commit,
  input logic                        e1_mode,
  input logic [SIG_W-1:0]            rd_data,
  input logic [N_SLOTS_E1*SIG_W-1:0] buf_flat
);

  // R5
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(buf_flat));

  // R6
  t1_tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !e1_mode) |=> $stable(buf_flat[N_SLOTS_E1*SIG_W-1 : N_SLOTS_T1*SIG_W]));

  // R4
  no_mf_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_sync && !mf_start) |=> (!cap_now || frame_sync));

  // R10
  commit_ends_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!cap_now || frame_sync));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_sync && (cur_bit != BIT_W'(SLOT_BITS - 1)))
      |=> (frame_sync || (cur_bit == $past(cur_bit) + 1'b1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (frame_sync || ($stable(cur_bit) && $stable(cur_slot))));

  // R9
  rd_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(rd_data));

endmodule

bind sig_mf_capture sig_mf_capture_chk #(
  .N_SLOTS_E1(N_SLOTS_E1), .N_SLOTS_T1(N_SLOTS_T1),
  .SLOT_BITS(SLOT_BITS), .SIG_W(SIG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
  .mf_start(mf_start), .cur_slot(cur_slot), .cur_bit(cur_bit),
  .cap_now(cap_now), .commit(commit), .e1_mode(e1_mode),
  .rd_data(rd_data), .buf_flat(buf_flat)
);

// File: tb/tb_sig_mf_capture.sv
module tb_sig_mf_capture;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       frame_sync;
  logic       mf_start;
  logic       e1_mode;
  logic       sig_bit;
  logic [4:0] rd_addr;
  logic [3:0] rd_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [3:0] model [32];

  always #5 clk = ~clk;

  sig_mf_capture dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .mf_start(mf_start), .e1_mode(e1_mode), .sig_bit(sig_bit),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [3:0] nib_of(int s, int seed);
    return 4'((s * 7 + seed * 3 + 1) % 16);
  endfunction

  function automatic logic [3:0] low_of(int s, int seed);
    return 4'(((s * 5 + seed) % 16) ^ 9);
  endfunction

  function automatic logic line_bit(int i, int seed);
    logic [7:0] byte_v;
    byte_v = {nib_of(i / 8, seed), low_of(i / 8, seed)};
    return byte_v[7 - (i % 8)];
  endfunction

  task automatic check_entry(string req, int a, logic [3:0] exp);
    rd_addr = 5'(a);
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s entry %0d: actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < 32; a++) check_entry(req, a, model[a]);
  endtask

  task automatic drive_bit(logic b, logic sync, logic mf, int gap);
    @(negedge clk);
    bit_en = 1'b1; sig_bit = b; frame_sync = sync; mf_start = mf;
    @(negedge clk);
    bit_en = 1'b0; frame_sync = 1'b0; mf_start = 1'b0; sig_bit = ~b;
    repeat (gap) @(negedge clk);
  endtask

  // Sends line bits [first, first+count) of a frame built from seed.
  task automatic send_bits(bit use_sync, bit mf, int seed, int gap, int first, int count);
    for (int i = first; i < first + count; i++)
      drive_bit(line_bit(i, seed), use_sync && (i == 0), mf && (i == 0), gap);
  endtask

  task automatic load_model(int nslots, int seed);
    for (int s = 0; s < nslots; s++) model[s] = nib_of(s, seed);
  endtask

  // R1
  task automatic t_reset();
    for (int a = 0; a < 32; a++) model[a] = 4'h0;
    check_all("R1");
  endtask

  // R2 R3 R5 R9: E1 multiframe capture, table old until the last bit
  task automatic t_e1_capture();
    e1_mode = 1'b1;
    send_bits(1'b1, 1'b1, 1, 0, 0, 255);
    check_entry("R5", 0, model[0]);
    check_entry("R5", 31, model[31]);
    send_bits(1'b0, 1'b0, 1, 0, 255, 1);
    load_model(32, 1);
    check_all("R3");
  endtask

  // R4: plain frame is not captured
  task automatic t_non_mf();
    send_bits(1'b1, 1'b0, 2, 0, 0, 256);
    check_all("R4");
  endtask

  // R10: capture then a flywheel frame with no sync
  task automatic t_flywheel();
    send_bits(1'b1, 1'b1, 3, 0, 0, 256);
    load_model(32, 3);
    check_all("R2");
    send_bits(1'b0, 1'b0, 4, 0, 0, 256);
    check_all("R10");
  endtask

  // R6: T1 capture keeps entries 24..31
  task automatic t_t1();
    e1_mode = 1'b0;
    send_bits(1'b1, 1'b1, 5, 0, 0, 192);
    load_model(24, 5);
    check_all("R6");
    e1_mode = 1'b1;
  endtask

  // R7 R8: aborted capture, then a gapped capture
  task automatic t_abort_gap();
    send_bits(1'b1, 1'b1, 6, 0, 0, 100);
    send_bits(1'b1, 1'b0, 7, 0, 0, 256);
    check_all("R7");
    send_bits(1'b1, 1'b1, 8, 2, 0, 256);
    load_model(32, 8);
    check_all("R8");
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; frame_sync = 1'b0; mf_start = 1'b0;
    e1_mode = 1'b1; sig_bit = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_e1_capture();
    t_non_mf();
    t_flywheel();
    t_t1();
    t_abort_gap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule